// File: doc/BRIEF.md
# Cascadable Synchronized Capture Time Base

This block holds two 16-bit counters that supply the time base for a pair of input capture channels. Each counter has its own gating unit. In synchronous mode the counter is held at zero until its sync source is enabled, and it is cleared by every sync pulse. In trigger mode the counter is held at zero until a trigger event sets a status flag. It then counts while that flag stays set, and software can drop the flag.

The two counters can be joined into one 32-bit counter. Slice 0 supplies the low half and slice 1 the high half. The low half's carry out advances the high half on the same clock edge. In this mode the high half ignores its own controls and follows the clear and advance decisions of the low slice, so the 32-bit value never tears.

Top module: `ctb_pair`

## Requirements
- R1: While `rst_n` is low, and right after it rises, both counts are zero and both trigger status bits are zero.
- R2: In synchronous mode (`trig_mode[i]`=0), with `src_en[i]`=1 and no pulse on `evt[i]`, a counter rises by one on each edge where `cnt_en[i]`=1 and holds where `cnt_en[i]`=0. With `cascade`=0 the two slices do not affect each other.
- R3: With `cascade`=0, a counter at 0xFFFF that advances goes to 0x0000, and the other counter is not affected.
- R4: In synchronous mode with `src_en[i]`=0, the counter is zero after each edge, whatever `cnt_en[i]` is.
- R5: In synchronous mode, a pulse on `evt[i]` makes the count zero on that edge. Counting resumes on the next edge.
- R6: In trigger mode (`trig_mode[i]`=1), the counter is held at zero while `trig_stat[i]`=0. An `evt[i]` pulse with `src_en[i]`=1 sets `trig_stat[i]` on that edge, and the count rises from the following edge. An `evt[i]` pulse with `src_en[i]`=0 has no effect.
- R7: In trigger mode, `stat_clr[i]`=1 clears `trig_stat[i]` on that edge, and the counter returns to zero on the next edge. When `stat_clr[i]` and a valid trigger arrive together, the status is set.
- R8: With `cascade`=1, `cnt_wide` equals {`cnt_hi`,`cnt_lo`}. The edge on which the low half wraps from 0xFFFF to 0x0000 also raises the high half by one.
- R9: With `cascade`=1, the high half ignores `trig_mode[1]`, `src_en[1]`, `evt[1]`, `stat_clr[1]` and `cnt_en[1]`. It is cleared whenever slice 0 clears, including while slice 0 waits for a trigger, and `trig_stat[1]` reads 0.
- R10: In synchronous mode, `trig_stat[i]` is zero after each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 2 | Count enable per slice (bit 0 low slice, bit 1 high slice) |
| cascade | input | 1 | Join both slices into one 32-bit counter |
| trig_mode | input | 2 | Per slice: 0 synchronous, 1 trigger |
| src_en | input | 2 | Sync/trigger source enabled per slice |
| evt | input | 2 | Sync or trigger pulse per slice |
| stat_clr | input | 2 | Software clear of the trigger status per slice |
| cnt_lo | output | 16 | Count of slice 0 |
| cnt_hi | output | 16 | Count of slice 1 |
| cnt_wide | output | 32 | {cnt_hi, cnt_lo} |
| trig_stat | output | 2 | Trigger status per slice |

## Verification
The assertions assume that every control input is synchronous to `clk` and holds a known value from reset onward. They also assume that `cascade` is read on the same edge as the carry it governs. The stimulus changes inputs only on the falling clock edge. It holds each pulse on `evt` or `stat_clr` for exactly one cycle. It switches `cascade` or a mode bit only between test phases, and a reference model carries its state across each switch.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

    typedef enum logic {
        MODE_SYNC = 1'b0,
        MODE_TRIG = 1'b1
    } ctb_mode_e;

    typedef struct packed {
        logic stat;
    } gate_reg_t;

    localparam int SLICES = 2;

endpackage

// File: rtl/ctb_gate.sv
module ctb_gate
    import ctb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_sel,
    input  logic src_en,
    input  logic evt,
    input  logic stat_clr,
    input  logic cnt_en,
    output logic stat_q,
    output logic clr,
    output logic adv
);

    ctb_mode_e mode;
    gate_reg_t r_d, r_q;

    assign mode = trig_sel ? MODE_TRIG : MODE_SYNC;

    always_comb begin
        r_d = r_q;
        clr = 1'b0;
        adv = 1'b0;
        if (mode == MODE_TRIG) begin
            if (src_en && evt) begin
                r_d.stat = 1'b1;
            end else if (stat_clr) begin
                r_d.stat = 1'b0;
            end
            clr = !r_q.stat;
            adv = r_q.stat && cnt_en;
        end else begin
            r_d.stat = 1'b0;
            clr = !src_en || evt;
            adv = cnt_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stat_q = r_q.stat;

    // R10
    sync_stat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_sel) |=> !stat_q);

    // R6
    trig_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel && src_en && evt) |=> stat_q);

    // R7
    stat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel && stat_clr && !(src_en && evt)) |=> !stat_q);

endmodule

// File: rtl/ctb_counter.sv
module ctb_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (adv) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_q = r_q.cnt;
    assign wrap  = adv && !clr && (r_q.cnt == '1);

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(cnt_q));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/ctb_pair.sv
module ctb_pair
    import ctb_pkg::*;
#(
    parameter int CW = 16,
    localparam int WW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cnt_en,
    input  logic          cascade,
    input  logic [1:0]    trig_mode,
    input  logic [1:0]    src_en,
    input  logic [1:0]    evt,
    input  logic [1:0]    stat_clr,
    output logic [CW-1:0] cnt_lo,
    output logic [CW-1:0] cnt_hi,
    output logic [WW-1:0] cnt_wide,
    output logic [1:0]    trig_stat
);

    logic [SLICES-1:0] g_clr, g_adv, g_sel;
    logic [SLICES-1:0] c_clr, c_adv, c_wrap;
    logic [CW-1:0]     cnt [SLICES];

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        if (i == 0) begin : g_lead
            assign g_sel[i] = trig_mode[i];
            assign c_clr[i] = g_clr[i];
            assign c_adv[i] = g_adv[i];
        end else begin : g_follow
            assign g_sel[i] = trig_mode[i] && !cascade;
            assign c_clr[i] = cascade ? c_clr[i-1]  : g_clr[i];
            assign c_adv[i] = cascade ? c_wrap[i-1] : g_adv[i];
        end

        ctb_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_sel (g_sel[i]),
            .src_en   (src_en[i]),
            .evt      (evt[i]),
            .stat_clr (stat_clr[i]),
            .cnt_en   (cnt_en[i]),
            .stat_q   (trig_stat[i]),
            .clr      (g_clr[i]),
            .adv      (g_adv[i])
        );

        ctb_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (c_clr[i]),
            .adv   (c_adv[i]),
            .cnt_q (cnt[i]),
            .wrap  (c_wrap[i])
        );
    end

    assign cnt_lo   = cnt[0];
    assign cnt_hi   = cnt[1];
    assign cnt_wide = {cnt[1], cnt[0]};

    // R8
    casc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && c_wrap[0]) |=> (cnt_hi == CW'($past(cnt_hi) + 1'b1)));

    // R9
    casc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && g_clr[0]) |=> (cnt_wide == '0));

    // R9
    casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !g_clr[0] && !c_wrap[0]) |=> $stable(cnt_hi));

    // R9
    casc_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |=> !trig_stat[1]);

endmodule

// File: tb/ctb_pair_tb.sv
module ctb_pair_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  en = '0, tm = '0, se = '0, ev = '0, sc = '0;
    logic        cas = 1'b0;
    logic [15:0] cnt_lo, cnt_hi;
    logic [31:0] cnt_wide;
    logic [1:0]  trig_stat;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] lo;
        logic [15:0] hi;
        logic [1:0]  st;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [15:0] m_lo = '0, m_hi = '0;
    logic [1:0]  m_st = '0;

    always #4 clk = ~clk;

    ctb_pair u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (en),
        .cascade   (cas),
        .trig_mode (tm),
        .src_en    (se),
        .evt       (ev),
        .stat_clr  (sc),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .cnt_wide  (cnt_wide),
        .trig_stat (trig_stat)
    );

    task automatic slice_ctl(input int i, input logic [1:0] st_now,
                             output logic c, output logic a, output logic s);
        if (tm[i]) begin
            c = !st_now[i];
            a = st_now[i] && en[i];
            s = (se[i] && ev[i]) ? 1'b1 : (sc[i] ? 1'b0 : st_now[i]);
        end else begin
            c = !se[i] || ev[i];
            a = en[i];
            s = 1'b0;
        end
    endtask

    task automatic model_step();
        logic c0, a0, s0, c1, a1, s1, w0;
        slice_ctl(0, m_st, c0, a0, s0);
        w0 = !c0 && a0 && (m_lo == 16'hFFFF);
        if (cas) begin
            c1 = c0;
            a1 = w0;
            s1 = 1'b0;
        end else begin
            slice_ctl(1, m_st, c1, a1, s1);
        end
        m_lo = c0 ? 16'h0 : (a0 ? m_lo + 16'h1 : m_lo);
        m_hi = c1 ? 16'h0 : (a1 ? m_hi + 16'h1 : m_hi);
        m_st = {s1, s0};
    endtask

    task automatic cyc(input int n, input bit chk, input string tag);
        for (int k = 0; k < n; k++) begin
            model_step();
            if (chk) q.push_back('{lo: m_lo, hi: m_hi, st: m_st, tag: tag});
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cnt_lo !== e.lo || cnt_hi !== e.hi || trig_stat !== e.st ||
                    cnt_wide !== {e.hi, e.lo}) begin
                    errors++;
                    $display("FAIL %s: lo=%h hi=%h wide=%h st=%b expected lo=%h hi=%h st=%b",
                             e.tag, cnt_lo, cnt_hi, cnt_wide, trig_stat, e.lo, e.hi, e.st);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        en = 2'b11;
        repeat (3) @(negedge clk);
        checks++;
        if (cnt_wide !== 32'h0 || trig_stat !== 2'b00) begin
            errors++;
            $display("FAIL R1: wide=%h st=%b expected wide=0 st=00", cnt_wide, trig_stat);
        end
        rst_n = 1'b1;
        checks++;
        if (cnt_wide !== 32'h0 || trig_stat !== 2'b00) begin
            errors++;
            $display("FAIL R1: after release wide=%h st=%b expected 0", cnt_wide, trig_stat);
        end

        // R4: source disabled, count enable high, stays zero
        cyc(5, 1, "R4");

        // R2: both count; slice 1 then held by cnt_en low
        se = 2'b11;
        cyc(8, 1, "R2");
        en = 2'b01;
        cyc(4, 1, "R2");
        en = 2'b11;

        // R5: sync pulse on slice 0 only
        ev = 2'b01;
        cyc(1, 1, "R5");
        ev = 2'b00;
        cyc(4, 1, "R5");

        // R3: independent wrap of slice 0, slice 1 keeps counting
        while (m_lo != 16'hFFF0) cyc(1, 0, "");
        cyc(24, 1, "R3");

        // R10 and R6: slice 0 in trigger mode, held at zero
        tm = 2'b01;
        cyc(4, 1, "R10");
        se[0] = 1'b0;
        ev[0] = 1'b1;
        cyc(1, 1, "R6");
        ev[0] = 1'b0;
        cyc(3, 1, "R6");
        se[0] = 1'b1;
        ev[0] = 1'b1;
        cyc(1, 1, "R6");
        ev[0] = 1'b0;
        cyc(6, 1, "R6");

        // R7: clear status, then clear and trigger together
        sc[0] = 1'b1;
        cyc(1, 1, "R7");
        sc[0] = 1'b0;
        cyc(4, 1, "R7");
        sc[0] = 1'b1;
        ev[0] = 1'b1;
        cyc(1, 1, "R7");
        sc[0] = 1'b0;
        ev[0] = 1'b0;
        cyc(4, 1, "R7");

        // R8 and R9: cascade, slice 1 controls set to disturb it
        tm = 2'b10;
        se = 2'b01;
        en = 2'b01;
        sc[1] = 1'b1;
        ev = 2'b11;
        cas = 1'b1;
        cyc(1, 1, "R9");
        ev = 2'b10;
        cyc(6, 1, "R9");
        while (m_lo != 16'hFFF8) cyc(1, 0, "");
        cyc(16, 1, "R8");

        // R9: cascade in trigger mode, both halves wait for slice 0
        tm = 2'b11;
        cyc(4, 1, "R9");
        ev = 2'b11;
        cyc(1, 1, "R9");
        ev = 2'b10;
        cyc(6, 1, "R9");
        sc[0] = 1'b1;
        cyc(1, 1, "R9");
        sc[0] = 1'b0;
        cyc(3, 1, "R9");

        @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule